// File: doc/BRIEF.md
# Flow-Through Synchronous Byte-Lane RAM

This block is a single-port synchronous RAM of 36-bit words, split into four 9-bit lanes (8 data bits and one parity bit per lane). On each rising clock edge it samples the address, write data, write controls and three chip enables. Writes are self-timed and commit at that edge. A read returns data for the address sampled at the edge. The data flows straight from the array to the outputs within that same clock period, with no extra output register. A sequencer in front of the RAM can therefore stream a burst at one word per clock once the first access has been issued.

Lane writes are chosen by priority. An all-lanes write strobe overrides everything else. Without it, a lane is written only when a common lane-write enable and that lane's own strobe are both active. An asynchronous output enable gates the read path. The high-impedance state of a pad driver is modelled by a valid flag, and the data bus is held at zero whenever that flag is low.

Top module: `fts_ram`

## Requirements
- R1: A word is 36 bits in four lanes. Lane i occupies bits [9*i+8:9*i] and is controlled by `lane_wr_n[i]`.
- R2: With the chip selected and `wr_all_n` low, all four lanes are written at the clock edge, whatever `lane_en_n` and `lane_wr_n` hold.
- R3: With `wr_all_n` high, lane i is written only when `lane_en_n` is low and `lane_wr_n[i]` is low. The other lanes keep their contents.
- R4: A cycle with `wr_all_n` high and either `lane_en_n` high or `lane_wr_n` equal to 4'b1111 is a read. It changes no stored data.
- R5: The chip is selected only when `cs0_n` is low, `cs1` is high and `cs2_n` is low at the clock edge. A deselected cycle writes nothing, and in the following period `rd_vld` is low.
- R6: `oe_n` acts without a clock. While it is high, `rd_vld` is low and `rdata` is zero.
- R7: For a selected read, `rdata` shows the word at the sampled address during the same clock period, with `rd_vld` high. Back-to-back reads deliver one word per clock.
- R8: A write followed on the next edge by a read of the same address returns the new bytes in the written lanes and the old bytes in the unwritten lanes.
- R9: While `rst_n` is low and after reset is released, `rd_vld` stays low until a selected read has been sampled.
- R10: During the period after a selected write edge, `rd_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the read-side state |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| wdata | input | 36 | Write data, four 9-bit lanes |
| wr_all_n | input | 1 | Active-low write of all lanes |
| lane_en_n | input | 1 | Active-low enable for per-lane writes |
| lane_wr_n | input | 4 | Active-low per-lane write strobes |
| cs0_n | input | 1 | Chip enable, active low |
| cs1 | input | 1 | Chip enable, active high |
| cs2_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 36 | Read data, zero when not valid |
| rd_vld | output | 1 | Read data is driven (models the pads leaving high impedance) |

## Verification
The bench goes after the write-priority mix. A design that let the lane enable or lane strobes mask an all-lanes write would keep stale bytes, and one that ignored the common enable would write lanes on a read cycle. Each chip enable is toggled on its own: a design that decoded any one of them with the wrong polarity would corrupt a word the bench reads back later, or raise `rd_vld` when the chip is deselected. A write followed at once by a read of the same address checks that unwritten lanes survive, that the new bytes are visible without a wait cycle, and that the output enable blanks the bus between clock edges rather than at the next one.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int N_LANES = 4;
  localparam int LANE_W  = 9;
  localparam int WORD_W  = N_LANES * LANE_W;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  // Lane write enable: all-lanes strobe wins; otherwise common enable AND lane strobe.
  function automatic logic lane_write(input logic all_n, input logic en_n, input logic strobe_n);
    return (!all_n) || (!en_n && !strobe_n);
  endfunction
endpackage

// File: rtl/fts_sel.sv
module fts_sel (
  input  logic cs0_n,
  input  logic cs1,
  input  logic cs2_n,
  output logic hit
);
  always_comb hit = !cs0_n && cs1 && !cs2_n;
endmodule

// File: rtl/fts_wr_decode.sv
module fts_wr_decode
  import fts_pkg::*;
(
  input  logic               sel,
  input  logic               wr_all_n,
  input  logic               lane_en_n,
  input  logic [N_LANES-1:0] lane_wr_n,
  output logic [N_LANES-1:0] lane_we,
  output cyc_e               cyc_kind
);
  logic [N_LANES-1:0] raw_we;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    always_comb raw_we[g] = lane_write(wr_all_n, lane_en_n, lane_wr_n[g]);
  end

  always_comb begin
    lane_we = sel ? raw_we : '0;
    if (!sel)         cyc_kind = CYC_IDLE;
    else if (|raw_we) cyc_kind = CYC_WRITE;
    else              cyc_kind = CYC_READ;
  end
endmodule

// File: rtl/fts_array.sv
module fts_array
  import fts_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LANES-1:0] we,
  input  logic [AW-1:0]      waddr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [AW-1:0]      raddr,
  output logic [WORD_W-1:0]  rdata
);
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_comb rdata[g*LANE_W +: LANE_W] = mem[raddr];

    // R8: a lane written at an edge reads back its new value when the read address matches
    a_r8_lane_landed: assert property (@(posedge clk) disable iff (!rst_n)
      we[g] |=> ((raddr != $past(waddr)) ||
                 (rdata[g*LANE_W +: LANE_W] == $past(wdata[g*LANE_W +: LANE_W]))));
  end
endmodule

// File: rtl/fts_ram.sv
module fts_ram
  import fts_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               wr_all_n,
  input  logic               lane_en_n,
  input  logic [N_LANES-1:0] lane_wr_n,
  input  logic               cs0_n,
  input  logic               cs1,
  input  logic               cs2_n,
  input  logic               oe_n,
  output logic [WORD_W-1:0]  rdata,
  output logic               rd_vld
);
  logic               sel_hit;
  logic [N_LANES-1:0] lane_we;
  cyc_e               cyc_kind;
  logic [AW-1:0]      addr_q;
  logic               rd_q;
  logic [WORD_W-1:0]  arr_rd;

  fts_sel u_sel (
    .cs0_n (cs0_n),
    .cs1   (cs1),
    .cs2_n (cs2_n),
    .hit   (sel_hit)
  );

  fts_wr_decode u_dec (
    .sel       (sel_hit),
    .wr_all_n  (wr_all_n),
    .lane_en_n (lane_en_n),
    .lane_wr_n (lane_wr_n),
    .lane_we   (lane_we),
    .cyc_kind  (cyc_kind)
  );

  fts_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (lane_we),
    .waddr (addr),
    .wdata (wdata),
    .raddr (addr_q),
    .rdata (arr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      addr_q <= addr;
      rd_q   <= (cyc_kind == CYC_READ);
    end
  end

  always_comb begin
    rd_vld = rd_q && !oe_n;
    rdata  = rd_vld ? arr_rd : '0;
  end

  // R2: all-lanes strobe overrides the lane controls
  a_r2_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hit && !wr_all_n) |-> (lane_we == '1));
  // R3/R4: without the all-lanes strobe, a high common enable blocks every lane
  a_r3_common_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_all_n && lane_en_n) |-> (lane_we == '0));
  // R5: deselected cycle writes nothing and yields no valid data next period
  a_r5_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hit |-> (lane_we == '0) ##1 !rd_vld);
  // R6: output enable high blanks the bus
  a_r6_oe_blank: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rd_vld && rdata == '0));
  // R10: a write cycle produces no valid read data
  a_r10_write_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |=> !rd_vld);
endmodule

// File: tb/fts_ram_tb.sv
module fts_ram_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [AW-1:0] addr;
  logic [35:0] wdata;
  logic        wr_all_n, lane_en_n;
  logic [3:0]  lane_wr_n;
  logic        cs0_n, cs1, cs2_n, oe_n;
  logic [35:0] rdata;
  logic        rd_vld;

  logic [35:0] model [DEPTH];
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  fts_ram #(.DEPTH(DEPTH), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_all_n(wr_all_n), .lane_en_n(lane_en_n), .lane_wr_n(lane_wr_n),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .oe_n(oe_n),
    .rdata(rdata), .rd_vld(rd_vld)
  );

  // vector: [49] all_n, [48] en_n, [47:44] lane strobes, [43:36] addr, [35:0] data
  localparam logic [49:0] VEC [10] = '{
    {1'b0, 1'b1, 4'b1111, 8'h10, 36'hABCDE1234},  // R2 all lanes despite idle lane controls
    {1'b1, 1'b0, 4'b1110, 8'h10, 36'h111111111},  // R3 lane 0 only
    {1'b1, 1'b0, 4'b0111, 8'h10, 36'hFEDCBA987},  // R3 lane 3 only
    {1'b1, 1'b0, 4'b1010, 8'h20, 36'h5A5A5A5A5},  // R3 lanes 0 and 2
    {1'b1, 1'b1, 4'b0000, 8'h20, 36'hFFFFFFFFF},  // R4 common enable high: no write
    {1'b1, 1'b0, 4'b1111, 8'h20, 36'h000000000},  // R4 all strobes high: no write
    {1'b0, 1'b0, 4'b0101, 8'h30, 36'h123456789},  // R2 all lanes with mixed strobes
    {1'b1, 1'b0, 4'b0000, 8'hFF, 36'h0F0F0F0F0},  // R3 all four via lanes
    {1'b1, 1'b0, 4'b1101, 8'h00, 36'h3C3C3C3C3},  // R1 lane 1 bits [17:9]
    {1'b1, 1'b0, 4'b1011, 8'h00, 36'h999999999}   // R1 lane 2 bits [26:18]
  };

  function automatic logic [35:0] fill_word(input int a);
    logic [7:0] b = a[7:0];
    return {1'b1, b, 1'b0, ~b, 1'b1, b ^ 8'h3C, 1'b0, b + 8'd7};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_ctl();
    wr_all_n = 1'b1; lane_en_n = 1'b1; lane_wr_n = 4'hF;
  endtask

  task automatic sel_on();
    cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
  endtask

  // apply one write-style cycle and update the model lane by lane
  task automatic wr_cyc(input logic an, input logic en, input logic [3:0] st,
                        input logic [7:0] a, input logic [35:0] d);
    addr = a; wdata = d; wr_all_n = an; lane_en_n = en; lane_wr_n = st;
    for (int l = 0; l < 4; l++)
      if (an == 1'b0 || (en == 1'b0 && st[l] == 1'b0))
        model[a][l*9 +: 9] = d[l*9 +: 9];
    step();
  endtask

  task automatic rd_cyc(input logic [7:0] a);
    addr = a; idle_ctl();
    step();
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; idle_ctl(); oe_n = 1'b0;
    cs0_n = 1'b1; cs1 = 1'b0; cs2_n = 1'b1;
    repeat (3) step();
    chk(rd_vld == 1'b0, "R9 in reset", {35'd0, rd_vld}, 36'd0);
    rst_n = 1'b1;
    step();
    chk(rd_vld == 1'b0, "R9 after reset", {35'd0, rd_vld}, 36'd0);

    sel_on();
    for (int a = 0; a < DEPTH; a++) begin
      wr_cyc(1'b0, 1'b1, 4'hF, a[7:0], fill_word(a));
      if (a % 64 == 0) chk(rd_vld == 1'b0, "R10 write period", {35'd0, rd_vld}, 36'd0);
    end

    // R7 streaming reads, one word per clock
    for (int a = 40; a < 48; a++) begin
      rd_cyc(a[7:0]);
      chk(rd_vld && rdata == model[a], "R7 burst beat", rdata, model[a]);
    end

    // table walk: each write followed at once by a read of the same address (R8)
    for (int i = 0; i < 10; i++) begin
      wr_cyc(VEC[i][49], VEC[i][48], VEC[i][47:44], VEC[i][43:36], VEC[i][35:0]);
      rd_cyc(VEC[i][43:36]);
      chk(rd_vld && rdata == model[VEC[i][43:36]], "R8 write then read", rdata, model[VEC[i][43:36]]);
    end

    // R5 each chip enable deasserted on its own: write blocked, read not valid
    for (int k = 0; k < 3; k++) begin
      sel_on();
      if (k == 0) cs0_n = 1'b1;
      if (k == 1) cs1 = 1'b0;
      if (k == 2) cs2_n = 1'b1;
      addr = 8'h55; wdata = 36'h0DEADBEEF; wr_all_n = 1'b0; lane_en_n = 1'b0; lane_wr_n = 4'h0;
      step();
      chk(rd_vld == 1'b0, "R5 deselected write", {35'd0, rd_vld}, 36'd0);
      rd_cyc(8'h55);
      chk(rd_vld == 1'b0, "R5 deselected read", {35'd0, rd_vld}, 36'd0);
      sel_on();
      rd_cyc(8'h55);
      chk(rd_vld && rdata == model[8'h55], "R5 word untouched", rdata, model[8'h55]);
    end

    // R6 asynchronous output enable within one period
    rd_cyc(8'h10);
    #1 oe_n = 1'b1;
    #1 chk(!rd_vld && rdata == 36'd0, "R6 oe high blanks", rdata, 36'd0);
    oe_n = 1'b0;
    #1 chk(rd_vld && rdata == model[8'h10], "R6 oe low restores", rdata, model[8'h10]);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule